// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block sits on the controller side of a reduced-latency DDR DRAM interface. It runs the start-up sequence the memory needs before any normal traffic. After a start pulse it keeps the command bus idle for a long stabilization wait. It then writes the mode register three times: two throw-away writes, then the real one. Next it refreshes every bank once, in bank order. Last, it waits out the row-cycle time and raises a ready flag.

The spacing between refreshes depends on one bit of the supplied mode word, the impedance-calibration enable.
- When the bit is set, the refreshes are spread far apart so the output drivers can calibrate.
- When the bit is clear, the refreshes follow one another at the short minimum refresh interval.

All intervals are parameters, so a bench can shrink them. The stabilization wait is the product of a clock-rate parameter in MHz and a duration in microseconds.

Top module: `mem_init_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released with no start, the outputs are: command NOP, bank zero, address zero, busy low, done low.
- R2: A start pulse sampled in the idle state raises busy on that same clock edge. The command bus then carries NOP for exactly CLK_MHZ*STAB_US cycles before the first mode-register write.
- R3: Three mode-register writes are issued on consecutive cycles. The first two drive address zero. The third drives the mode word that was captured at start.
- R4: The first refresh appears exactly T_MRSC cycles after the third mode-register write.
- R5: BANKS refresh commands are issued, with the bank output stepping 0, 1, 2 and so on in order.
- R6: When bit IMP_BIT of the captured mode word is 1, consecutive refreshes are exactly REF_GAP_CAL cycles apart.
- R7: When that bit is 0, consecutive refreshes are exactly REF_GAP_MIN cycles apart.
- R8: Done rises, and busy falls on the same edge, exactly T_RC cycles after the last refresh.
- R9: The command encodings are NOP = 0, mode-register write = 1 and refresh = 2. In every cycle that carries NOP, bank and address are zero.
- R10: Done stays high until reset. A start pulse that arrives while busy or done is ignored. The mode word is sampled only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| mode_i | input | ADDR_W | Mode word; bit IMP_BIT enables impedance calibration |
| cmd_o | output | 2 | Command: 0 NOP, 1 mode-register write, 2 refresh |
| bank_o | output | $clog2(BANKS) | Bank address |
| addr_o | output | ADDR_W | Address bus, carries the valid mode word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Memory ready, sticky until reset |

## Verification
The bench compares every output on every cycle against a timeline computed from the captured mode word. Because of that, an off-by-one in any wait counter shifts a command and is reported.

Mode words are changed right after start and again by start pulses injected during stabilization, during the mode writes, and after done. A design that re-samples the mode word or restarts would show a wrong third-write address, a shifted refresh gap, or a second sequence.

Both settings of the impedance bit are run. A design that ignores the bit, or reads it live instead of from the captured word, would space the refreshes by the wrong amount.

A design that let bank or address leak into idle cycles fails the per-cycle zero check.

// File: rtl/pu_init_pkg.sv
package pu_init_pkg;

   typedef enum logic [1:0] {
      PU_NOP = 2'd0,
      PU_MRS = 2'd1,
      PU_REF = 2'd2
   } pu_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STAB,
      ST_MRS,
      ST_WMRSC,
      ST_WREF,
      ST_WRC,
      ST_DONE
   } pu_state_e;

endpackage

// File: rtl/pu_interval_timer.sv
module pu_interval_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] value_i,
   output logic         expired_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= value_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pu_cmd_reg.sv
module pu_cmd_reg
   import pu_init_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pu_cmd_e           cmd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [1:0]        cmd_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [ADDR_W-1:0] addr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o  <= PU_NOP;
         bank_o <= '0;
         addr_o <= '0;
      end else begin
         cmd_o  <= cmd_i;
         bank_o <= bank_i;
         addr_o <= addr_i;
      end
   end

endmodule

// File: rtl/mem_init_sequencer.sv
module mem_init_sequencer
   import pu_init_pkg::*;
#(
   parameter int CLK_MHZ     = 300,
   parameter int STAB_US     = 200,
   parameter int T_MRSC      = 6,
   parameter int T_RC        = 8,
   parameter int REF_GAP_CAL = 2048,
   parameter int REF_GAP_MIN = 8,
   parameter int BANKS       = 8,
   parameter int ADDR_W      = 20,
   parameter int IMP_BIT     = 9,
   localparam int BANK_W     = $clog2(BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] mode_i,
   output logic [1:0]        cmd_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int STAB_CYC = CLK_MHZ * STAB_US;
   localparam int MAX_A    = (STAB_CYC > REF_GAP_CAL) ? STAB_CYC : REF_GAP_CAL;
   localparam int MAX_B    = (T_MRSC > T_RC) ? T_MRSC : T_RC;
   localparam int MAX_C    = (MAX_B > REF_GAP_MIN) ? MAX_B : REF_GAP_MIN;
   localparam int MAX_IV   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
   localparam int CNT_W    = $clog2(MAX_IV + 1);
   localparam int IDX_W    = (BANK_W > 2) ? BANK_W : 2;

   localparam logic [CNT_W-1:0] STAB_LD = CNT_W'(STAB_CYC - 1);
   localparam logic [CNT_W-1:0] MRSC_LD = CNT_W'(T_MRSC - 1);
   localparam logic [CNT_W-1:0] RC_LD   = CNT_W'(T_RC - 1);
   localparam logic [IDX_W-1:0] LAST_BK = IDX_W'(BANKS - 1);
   localparam logic [IDX_W-1:0] MRS_LST = IDX_W'(2);

   // elaboration-time parameter checks
   if (BANKS < 2 || (1 << BANK_W) != BANKS)
      $error("BANKS must be a power of two and at least 2");
   if (STAB_CYC < 1 || T_MRSC < 1 || T_RC < 1 || REF_GAP_MIN < 1 || REF_GAP_CAL < 1)
      $error("all intervals must be at least one cycle");
   if (IMP_BIT >= ADDR_W)
      $error("IMP_BIT must lie inside the mode word");

   pu_state_e         st_q, st_n;
   logic [IDX_W-1:0]  idx_q, idx_n;
   logic [ADDR_W-1:0] mode_q;
   logic              imp_q;
   logic              busy_q, busy_n, done_q, done_n;
   logic              capture;
   logic              tmr_load, tmr_exp;
   logic [CNT_W-1:0]  tmr_val, gap_ld;
   pu_cmd_e           cmd_n;
   logic [BANK_W-1:0] bank_n;
   logic [ADDR_W-1:0] addr_n;

   // refresh spacing: fold to a constant when both gaps match
   if (REF_GAP_CAL == REF_GAP_MIN) begin : g_gap_fixed
      assign gap_ld = CNT_W'(REF_GAP_MIN - 1);
   end else begin : g_gap_sel
      assign gap_ld = imp_q ? CNT_W'(REF_GAP_CAL - 1) : CNT_W'(REF_GAP_MIN - 1);
   end

   always_comb begin
      st_n     = st_q;
      idx_n    = idx_q;
      busy_n   = busy_q;
      done_n   = done_q;
      capture  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cmd_n    = PU_NOP;
      bank_n   = '0;
      addr_n   = '0;
      unique case (st_q)
         ST_IDLE: if (start_i) begin
            st_n     = ST_STAB;
            busy_n   = 1'b1;
            capture  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = STAB_LD;
         end
         ST_STAB: if (tmr_exp) begin
            cmd_n = PU_MRS;
            idx_n = IDX_W'(1);
            st_n  = ST_MRS;
         end
         ST_MRS: begin
            cmd_n = PU_MRS;
            if (idx_q == MRS_LST) begin
               addr_n   = mode_q;
               st_n     = ST_WMRSC;
               tmr_load = 1'b1;
               tmr_val  = MRSC_LD;
            end else begin
               idx_n = idx_q + 1'b1;
            end
         end
         ST_WMRSC: if (tmr_exp) begin
            cmd_n    = PU_REF;
            idx_n    = IDX_W'(1);
            st_n     = ST_WREF;
            tmr_load = 1'b1;
            tmr_val  = gap_ld;
         end
         ST_WREF: if (tmr_exp) begin
            cmd_n    = PU_REF;
            bank_n   = idx_q[BANK_W-1:0];
            tmr_load = 1'b1;
            if (idx_q == LAST_BK) begin
               st_n    = ST_WRC;
               tmr_val = RC_LD;
            end else begin
               idx_n   = idx_q + 1'b1;
               tmr_val = gap_ld;
            end
         end
         ST_WRC: if (tmr_exp) begin
            st_n   = ST_DONE;
            busy_n = 1'b0;
            done_n = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         mode_q <= '0;
         imp_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         idx_q  <= idx_n;
         busy_q <= busy_n;
         done_q <= done_n;
         if (capture) begin
            mode_q <= mode_i;
            imp_q  <= mode_i[IMP_BIT];
         end
      end
   end

   pu_interval_timer #(.W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .value_i   (tmr_val),
      .expired_o (tmr_exp)
   );

   pu_cmd_reg #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_i  (cmd_n),
      .bank_i (bank_n),
      .addr_i (addr_n),
      .cmd_o  (cmd_o),
      .bank_o (bank_o),
      .addr_o (addr_o)
   );

   assign busy_o = busy_q;
   assign done_o = done_q;

endmodule

// File: rtl/pu_init_checker.sv
module pu_init_checker #(
   parameter int BANKS       = 8,
   parameter int ADDR_W      = 20,
   parameter int REF_GAP_MIN = 8,
   localparam int BANK_W     = $clog2(BANKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd_o,
   input logic [BANK_W-1:0] bank_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              busy_o,
   input logic              done_o
);

   logic [BANK_W:0] ref_seen;
   logic [2:0]      mrs_seen;
   logic [31:0]     since_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_seen  <= '0;
         mrs_seen  <= '0;
         since_ref <= '0;
      end else begin
         if (cmd_o == 2'd2) ref_seen <= ref_seen + 1'b1;
         if (cmd_o == 2'd1) mrs_seen <= mrs_seen + 1'b1;
         if (cmd_o == 2'd2) since_ref <= 32'd1;
         else if (since_ref != 32'hFFFF_FFFF) since_ref <= since_ref + 1'b1;
      end
   end

   assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd0) |-> (bank_o == '0 && addr_o == '0));

   assert_cmd_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != 2'd0) |-> busy_o);

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && !busy_o));

   assert_bank_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd2) |-> ({1'b0, bank_o} == ref_seen));

   assert_mrs_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd2) |-> (mrs_seen == 3'd3));

   assert_ref_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd2 && ref_seen != '0) |-> (since_ref >= 32'(REF_GAP_MIN)));

   assert_done_after_refs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (ref_seen == (BANK_W+1)'(BANKS)));

endmodule

bind mem_init_sequencer pu_init_checker #(
   .BANKS(BANKS), .ADDR_W(ADDR_W), .REF_GAP_MIN(REF_GAP_MIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .bank_o(bank_o),
   .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_mem_init_sequencer.sv
module tb_mem_init_sequencer;

   localparam int CLK_MHZ = 10;
   localparam int STAB_US = 3;
   localparam int S       = CLK_MHZ * STAB_US;
   localparam int T_MRSC  = 4;
   localparam int T_RC    = 6;
   localparam int GAP_CAL = 20;
   localparam int GAP_MIN = 3;
   localparam int BANKS   = 8;
   localparam int ADDR_W  = 20;
   localparam int IMP_BIT = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] mode_in = '0;
   logic [1:0]        cmd;
   logic [2:0]        bank;
   logic [ADDR_W-1:0] addr;
   logic              busy, done;

   int vectors = 0;
   int fails   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mem_init_sequencer #(
      .CLK_MHZ(CLK_MHZ), .STAB_US(STAB_US), .T_MRSC(T_MRSC), .T_RC(T_RC),
      .REF_GAP_CAL(GAP_CAL), .REF_GAP_MIN(GAP_MIN), .BANKS(BANKS),
      .ADDR_W(ADDR_W), .IMP_BIT(IMP_BIT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode_in),
      .cmd_o(cmd), .bank_o(bank), .addr_o(addr), .busy_o(busy), .done_o(done)
   );

   function automatic int gap_of(logic [ADDR_W-1:0] m);
      return m[IMP_BIT] ? GAP_CAL : GAP_MIN;
   endfunction

   function automatic int first_ref();
      return S + 2 + T_MRSC;
   endfunction

   function automatic int done_at(logic [ADDR_W-1:0] m);
      return first_ref() + (BANKS - 1) * gap_of(m) + T_RC;
   endfunction

   // expected outputs "off" cycles after the accepting edge
   function automatic void expect_at(input int off, input logic [ADDR_W-1:0] m,
                                     output logic [1:0] c, output logic [2:0] b,
                                     output logic [ADDR_W-1:0] a, output logic bz,
                                     output logic dn, output string tag);
      int g = gap_of(m);
      int r0 = first_ref();
      c = 2'd0; b = '0; a = '0;
      bz = (off < done_at(m));
      dn = !bz;
      tag = (off < S) ? "R2" : "R9";
      if (off == S || off == S + 1) begin
         c = 2'd1; tag = "R3";
      end else if (off == S + 2) begin
         c = 2'd1; a = m; tag = "R3";
      end else if (off >= r0 && off <= r0 + (BANKS - 1) * g && ((off - r0) % g) == 0) begin
         c = 2'd2; b = 3'((off - r0) / g);
         tag = (off == r0) ? "R4" : (m[IMP_BIT] ? "R6" : "R7");
      end else if (dn) begin
         tag = "R8";
      end
   endfunction

   task automatic check(input string tag, input logic [1:0] ec, input logic [2:0] eb,
                        input logic [ADDR_W-1:0] ea, input logic eb_z, input logic edn,
                        input int off);
      vectors++;
      if (cmd !== ec || bank !== eb || addr !== ea || busy !== eb_z || done !== edn) begin
         fails++;
         $display("FAIL %s off=%0d got cmd=%0d bank=%0d addr=%h busy=%b done=%b exp cmd=%0d bank=%0d addr=%h busy=%b done=%b",
                  tag, off, cmd, bank, addr, busy, done, ec, eb, ea, eb_z, edn);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", 2'd0, '0, '0, 1'b0, 1'b0, -1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", 2'd0, '0, '0, 1'b0, 1'b0, -1);
   endtask

   // run one sequence; a second start with another mode is injected at inj_off (R10)
   task automatic run_seq(input logic [ADDR_W-1:0] m, input int inj_off,
                          input logic [ADDR_W-1:0] inj_mode);
      logic [1:0] c; logic [2:0] b; logic [ADDR_W-1:0] a; logic bz, dn; string tag;
      int last = done_at(m) + 4;
      start = 1'b1; mode_in = m;
      @(negedge clk);
      start = 1'b0; mode_in = m ^ {ADDR_W{1'b1}};   // R10: mode must be captured, not live
      for (int off = 0; off <= last; off++) begin
         expect_at(off, m, c, b, a, bz, dn, tag);
         if (off == inj_off) tag = {tag, "/R10"};
         check(tag, c, b, a, bz, dn, off);
         if (off == inj_off) begin
            start = 1'b1; mode_in = inj_mode;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   initial begin
      int seed_dummy;
      logic [ADDR_W-1:0] m;
      seed_dummy = $urandom(32'd20240611);
      @(negedge clk);
      do_reset();
      // directed: calibration on, second start during stabilization
      m = ADDR_W'(20'h0A5C3) | (ADDR_W'(1) << IMP_BIT);
      run_seq(m, 5, ~m);
      do_reset();
      // directed: calibration off, second start during mode writes
      m = ADDR_W'(20'hF1234) & ~(ADDR_W'(1) << IMP_BIT);
      run_seq(m, S + 1, ~m);
      do_reset();
      // directed: calibration on, start after done is ignored
      m = ADDR_W'(20'h00200);
      run_seq(m, done_at(m) + 1, ADDR_W'(20'hFFFFF));
      // random runs
      for (int i = 0; i < 6; i++) begin
         do_reset();
         m = ADDR_W'($urandom);
         run_seq(m, int'($urandom_range(0, done_at(m) + 3)), ADDR_W'($urandom));
      end
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog expired got running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule